// File: doc/BRIEF.md
# RDS Group Reporting and Interrupt Unit

This block takes the output of an RDS block synchronizer and error corrector: at most one 16-bit information word per cycle, with its position in the group (A, B, C or D), the number of bit errors the corrector fixed, and a flag saying whether the decoder is locked. It turns the bit-error count into a two-bit quality category. It puts four consecutive blocks in the order A, B, C, D together into a group. Complete groups go into a FIFO of groups that a host drains through a small register interface.

The host can read data in two ways. It can take the most recent accepted block on its own, with that block's category and position. It can also take whole groups from the FIFO head, with one category per block. Sticky flags record five events: a completed group, a change in the content of block A, a change in the content of block B, the FIFO level reaching a programmable threshold, and a group lost to a full FIFO. A single interrupt line is the OR of the enabled flags. Writing ones to the flag register clears flags.

Top module: `rds_group_reporter`

## Requirements
- R1: The error category is 2'b00 for 0 bit errors, 2'b01 for 1 or 2, 2'b10 for 3 to 5 and 2'b11 (uncorrectable) for 6 or more. An uncorrectable block is stored with its word forced to zero.
- R2: A block that arrives while `blk_sync` is low is discarded and flushes any partial group. FLAGS bit 5 shows `blk_sync` as registered one cycle earlier.
- R3: Blocks accepted in the order A=0, B=1, C=2, D=3 form one group, which is pushed when D arrives. Register 4 holds the head categories, with A in bits 1:0 up to D in bits 7:6. Registers 8 to 11 hold the head words A to D. All of these read 0 when the FIFO is empty. A write to register 4 pops the head. The level is in FLAGS bits 15:8.
- R4: A block in an unexpected position discards the partial group. If that block is an A, it starts a new group. Any other position is dropped.
- R5: FLAGS bit 0 sets on every completed group, including a group that is then dropped.
- R6: FLAGS bit 1 sets when an accepted A block that is not uncorrectable differs from the last such A stored. The first one after reset counts as a change. Uncorrectable A blocks are ignored.
- R7: FLAGS bit 2 does the same for B blocks.
- R8: FLAGS bit 3 sets while the FIFO level is at or above the threshold in CTRL bits 8:4. A threshold of 0 acts as 1, and a value above 25 acts as 25.
- R9: Flags are sticky. Writing register 1 clears the flags whose bits in data 4:0 are one. A set condition in the same cycle wins over the clear.
- R10: `irq` is high when any of FLAGS bits 3:0 is set and its enable in CTRL bits 3:0 is set. The enables are group, A change, B change and threshold, in that order. CTRL reads back what was written.
- R11: The FIFO holds 32 groups. A group completed while the FIFO is full is dropped, and FLAGS bit 4 (overflow) sets.
- R12: Register 2 holds the word of the last accepted block. Register 3 holds its category in bits 1:0, its position in bits 3:2, and in bit 4 a flag that a block has been accepted.
- R13: A pop on an empty FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A block is offered this cycle |
| blk_word | input | 16 | Corrected information word |
| blk_pos | input | 2 | Block position, A=0 to D=3 |
| blk_errs | input | 4 | Corrected bit-error count, 15 or above 5 = uncorrectable |
| blk_sync | input | 1 | Decoder synchronized |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the category boundaries at 2/3, 5/6 and 15 error bits. A design that is off by one at any of these would give the wrong code, and a design that forgets to zero uncorrectable words would leak corrupt data. The bench also sends blocks out of order and while unsynchronized. A design that does not flush the partial group would emit groups that mix words from two different groups. The bench fills the FIFO past 32 groups and pops it while empty; a design that wraps the pointers or the level would corrupt the head or report a false level. It also checks that an uncorrectable A or B does not count as a content change. Finally it clears flags while their set condition still holds; a design that lets the clear win there would lose threshold events.

// File: rtl/rds_group_reporter.sv
module rds_group_reporter #(
  parameter int DEPTH   = 32,
  parameter int MAX_THR = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_valid,
  input  logic [15:0] blk_word,
  input  logic [1:0]  blk_pos,
  input  logic [3:0]  blk_errs,
  input  logic        blk_sync,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [1:0]    nxt;
  logic [15:0]   pw [4];
  logic [1:0]    pc [4];
  logic [71:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] count;
  logic [4:0]    flags;
  logic [3:0]    en;
  logic [4:0]    thr;
  logic          sync_q;
  logic [15:0]   a_last, b_last;
  logic          a_ok, b_ok;
  logic [15:0]   last_word;
  logic [1:0]    last_cat, last_pos;
  logic          last_ok;

  logic [1:0]  cat;
  logic [15:0] word_c;
  logic        take, in_order, complete, push, pop, drop, a_chg, b_chg, thr_hit;
  logic [4:0]  thr_eff, clr;
  logic [71:0] head;

  assign cat      = (blk_errs == 4'd0) ? 2'b00 :
                    (blk_errs <= 4'd2) ? 2'b01 :
                    (blk_errs <= 4'd5) ? 2'b10 : 2'b11;
  assign word_c   = (cat == 2'b11) ? 16'h0000 : blk_word;
  assign take     = blk_valid & blk_sync;
  assign in_order = take && (blk_pos == nxt);
  assign complete = in_order && (blk_pos == 2'd3);
  assign pop      = reg_wr && (reg_addr == 4'd4) && (count != '0);
  assign push     = complete && (count != LW'(DEPTH));
  assign drop     = complete && (count == LW'(DEPTH));
  assign a_chg    = take && blk_pos == 2'd0 && cat != 2'b11 && (!a_ok || blk_word != a_last);
  assign b_chg    = take && blk_pos == 2'd1 && cat != 2'b11 && (!b_ok || blk_word != b_last);
  assign thr_eff  = (thr == 5'd0) ? 5'd1 : (thr > 5'(MAX_THR)) ? 5'(MAX_THR) : thr;
  assign thr_hit  = count >= LW'(thr_eff);
  assign clr      = (reg_wr && reg_addr == 4'd1) ? reg_wdata[4:0] : 5'd0;
  assign head     = (count == '0) ? 72'd0 : mem[rp];
  assign irq      = |(flags[3:0] & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt <= 2'd0;
      for (int i = 0; i < 4; i++) begin
        pw[i] <= 16'd0;
        pc[i] <= 2'd0;
      end
    end else if (blk_valid && !blk_sync) begin
      nxt <= 2'd0;
    end else if (take) begin
      if (in_order) nxt <= nxt + 2'd1;
      else          nxt <= (blk_pos == 2'd0) ? 2'd1 : 2'd0;
      if (in_order || blk_pos == 2'd0) begin
        pw[blk_pos] <= word_c;
        pc[blk_pos] <= cat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {cat, pc[2], pc[1], pc[0], word_c, pw[2], pw[1], pw[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= 5'd0;
      en <= 4'd0;
      thr <= 5'd0;
      sync_q <= 1'b0;
      a_last <= 16'd0;
      b_last <= 16'd0;
      a_ok <= 1'b0;
      b_ok <= 1'b0;
      last_word <= 16'd0;
      last_cat <= 2'd0;
      last_pos <= 2'd0;
      last_ok <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | {drop, thr_hit, b_chg, a_chg, complete};
      sync_q <= blk_sync;
      if (reg_wr && reg_addr == 4'd0) begin
        en <= reg_wdata[3:0];
        thr <= reg_wdata[8:4];
      end
      if (take && blk_pos == 2'd0 && cat != 2'b11) begin
        a_last <= blk_word;
        a_ok <= 1'b1;
      end
      if (take && blk_pos == 2'd1 && cat != 2'b11) begin
        b_last <= blk_word;
        b_ok <= 1'b1;
      end
      if (take) begin
        last_word <= word_c;
        last_cat <= cat;
        last_pos <= blk_pos;
        last_ok <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {7'd0, thr, en};
      4'd1:    reg_rdata = {8'(count), 2'b00, sync_q, flags};
      4'd2:    reg_rdata = last_word;
      4'd3:    reg_rdata = {11'd0, last_ok, last_pos, last_cat};
      4'd4:    reg_rdata = {8'd0, head[71:64]};
      4'd8:    reg_rdata = head[15:0];
      4'd9:    reg_rdata = head[31:16];
      4'd10:   reg_rdata = head[47:32];
      4'd11:   reg_rdata = head[63:48];
      default: reg_rdata = 16'd0;
    endcase
  end
endmodule

module rds_group_reporter_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_valid,
  input logic          blk_sync,
  input logic [3:0]    blk_errs,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [15:0]   reg_wdata,
  input logic [1:0]    last_cat,
  input logic [15:0]   last_word,
  input logic [LW-1:0] count,
  input logic [4:0]    flags,
  input logic          complete
);
  assert_uncorr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_sync && blk_errs > 4'd5 |=> last_cat == 2'b11 && last_word == 16'd0);

  assert_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_sync && !(reg_wr && reg_addr == 4'd4) |=> $stable(count));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !(reg_wr && reg_addr == 4'd1 && reg_wdata[0]) |=> flags[0]);

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count == LW'(DEPTH) && complete && !(reg_wr && reg_addr == 4'd4) |=> count == LW'(DEPTH) && flags[4]);

  assert_empty_pop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 && reg_wr && reg_addr == 4'd4 && !complete |=> count == '0);

  always @(posedge clk)
    if (rst_n) assert_level_bound_R11: assert (count <= LW'(DEPTH));
endmodule

bind rds_group_reporter rds_group_reporter_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/test_rds_group_reporter.sv
module test_rds_group_reporter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_valid = 1'b0, blk_sync = 1'b0, reg_wr = 1'b0;
  logic [15:0] blk_word = '0, reg_wdata = '0;
  logic [1:0] blk_pos = '0;
  logic [3:0] blk_errs = '0, reg_addr = '0;
  logic [15:0] reg_rdata;
  logic irq;

  always #5 clk = ~clk;

  rds_group_reporter i_rds_group_reporter (.*);

  int compared = 0, mismatched = 0;
  int m_nxt = 0;
  logic [15:0] m_pw [4];
  logic [1:0] m_pc [4];
  logic [71:0] m_q [$];
  logic [4:0] m_flags = '0;
  logic [3:0] m_en = '0;
  logic [4:0] m_thr = '0;
  logic [15:0] m_alast, m_blast, m_lword = '0;
  logic m_aok = 0, m_bok = 0, m_lok = 0, m_sync = 0;
  logic [1:0] m_lcat = '0, m_lpos = '0;

  function automatic logic [1:0] cat_of(input logic [3:0] e);
    if (e == 0) return 2'b00;
    if (e <= 2) return 2'b01;
    if (e <= 5) return 2'b10;
    return 2'b11;
  endfunction

  function automatic int thr_eff();
    if (m_thr == 0) return 1;
    if (m_thr > 25) return 25;
    return int'(m_thr);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic model_thr();
    if (m_q.size() >= thr_eff()) m_flags[3] = 1'b1;
  endtask

  task automatic send(input logic [15:0] w, input logic [1:0] p, input logic [3:0] e, input logic s);
    logic [1:0] c;
    logic [15:0] wc;
    @(negedge clk);
    blk_valid = 1; blk_word = w; blk_pos = p; blk_errs = e; blk_sync = s;
    @(negedge clk);
    blk_valid = 0;
    @(negedge clk);
    c = cat_of(e);
    wc = (c == 2'b11) ? 16'h0 : w;
    m_sync = s;
    if (!s) m_nxt = 0;
    else begin
      if (p == 2'(m_nxt) || p == 0) begin m_pw[p] = wc; m_pc[p] = c; end
      if (p == 2'(m_nxt)) begin
        m_nxt = (m_nxt + 1) % 4;
        if (p == 3) begin
          m_flags[0] = 1;
          if (m_q.size() < 32) m_q.push_back({c, m_pc[2], m_pc[1], m_pc[0], wc, m_pw[2], m_pw[1], m_pw[0]});
          else m_flags[4] = 1;
        end
      end else m_nxt = (p == 0) ? 1 : 0;
      if (p == 0 && c != 2'b11) begin
        if (!m_aok || w != m_alast) m_flags[1] = 1;
        m_alast = w; m_aok = 1;
      end
      if (p == 1 && c != 2'b11) begin
        if (!m_bok || w != m_blast) m_flags[2] = 1;
        m_blast = w; m_bok = 1;
      end
      m_lword = wc; m_lcat = c; m_lpos = p; m_lok = 1;
    end
    model_thr();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) begin m_en = d[3:0]; m_thr = d[8:4]; end
    if (a == 1) m_flags = m_flags & ~d[4:0];
    if (a == 4 && m_q.size() != 0) void'(m_q.pop_front());
    model_thr();
    @(negedge clk);
  endtask

  task automatic check_status();
    logic [15:0] v;
    rd(4'd1, v);
    chk("R3 level", {8'd0, v[15:8]}, 16'(m_q.size()));
    chk("R2 sync", {15'd0, v[5]}, {15'd0, m_sync});
    chk("R5 group flag", {15'd0, v[0]}, {15'd0, m_flags[0]});
    chk("R6 A change flag", {15'd0, v[1]}, {15'd0, m_flags[1]});
    chk("R7 B change flag", {15'd0, v[2]}, {15'd0, m_flags[2]});
    chk("R8 threshold flag", {15'd0, v[3]}, {15'd0, m_flags[3]});
    chk("R11 overflow flag", {15'd0, v[4]}, {15'd0, m_flags[4]});
    chk("R10 irq", {15'd0, irq}, {15'd0, |(m_flags[3:0] & m_en)});
    rd(4'd2, v);
    chk("R12 last word", v, m_lword);
    rd(4'd3, v);
    chk("R12 last info", v, {11'd0, m_lok, m_lpos, m_lcat});
  endtask

  task automatic check_head();
    logic [15:0] v;
    logic [71:0] h;
    h = (m_q.size() == 0) ? 72'd0 : m_q[0];
    rd(4'd4, v);
    chk("R3 head categories", v, {8'd0, h[71:64]});
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), v);
      chk("R3 head word", v, h[16*i +: 16]);
    end
  endtask

  task automatic send_group(input logic [15:0] base, input logic [3:0] e);
    for (int i = 0; i < 4; i++) send(base + 16'(i), 2'(i), e, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] pool [4];
    pool[0] = 16'h1234; pool[1] = 16'h1235; pool[2] = 16'hBEEF; pool[3] = 16'h0000;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd0, v); chk("R10 reset ctrl", v, 16'd0);
    check_status();
    check_head();

    // R1 category boundaries through the last-block registers
    send(16'hAAAA, 2'd2, 4'd2, 1'b1); check_status();
    send(16'hAAAA, 2'd2, 4'd3, 1'b1); check_status();
    send(16'hAAAA, 2'd2, 4'd5, 1'b1); check_status();
    send(16'hAAAA, 2'd2, 4'd6, 1'b1); check_status();
    send(16'hAAAA, 2'd2, 4'd15, 1'b1); check_status();
    send(16'hAAAA, 2'd2, 4'd0, 1'b1); check_status();

    // R4 out-of-order A restarts, then R2 unsynced block flushes
    wr(4'd0, 16'h00F); rd(4'd0, v); chk("R10 ctrl readback", v, 16'h00F);
    send(16'h1000, 2'd0, 4'd0, 1'b1);
    send(16'h1001, 2'd1, 4'd1, 1'b1);
    send_group(16'h2000, 4'd4);
    check_status(); check_head();
    send(16'h3000, 2'd0, 4'd0, 1'b1);
    send(16'h3001, 2'd1, 4'd0, 1'b0);
    send(16'h3002, 2'd2, 4'd0, 1'b1);
    send(16'h3003, 2'd3, 4'd0, 1'b1);
    check_status();

    // R6 uncorrectable A ignored for change detection
    wr(4'd1, 16'h1F); check_status();
    send(16'h2000, 2'd0, 4'd9, 1'b1); check_status();
    send(16'h2000, 2'd0, 4'd0, 1'b1); check_status();

    // R13 pop on empty, R8 clamps, R11 overflow
    while (m_q.size() != 0) wr(4'd4, 16'd0);
    wr(4'd4, 16'd0); check_status(); check_head();
    wr(4'd0, 16'h1F0);
    wr(4'd1, 16'h1F);
    for (int g = 0; g < 33; g++) begin
      send_group(16'(g * 16), 4'(g % 8));
      if (g == 23 || g == 24) check_status();
    end
    check_status(); check_head();
    wr(4'd1, 16'h08); check_status();
    wr(4'd0, 16'h00F);
    while (m_q.size() != 0) begin check_head(); wr(4'd4, 16'd0); end
    wr(4'd1, 16'h1F); check_status();

    // constrained random traffic
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [1:0] p;
      r = int'($urandom_range(0, 99));
      p = (r < 85) ? 2'(m_nxt) : 2'($urandom_range(0, 3));
      send(pool[$urandom_range(0, 3)], p, 4'($urandom_range(0, 15) < 10 ? $urandom_range(0, 2) : $urandom_range(0, 15)),
           $urandom_range(0, 99) < 95);
      check_status();
      r = int'($urandom_range(0, 99));
      if (r < 20) begin check_head(); wr(4'd4, 16'd0); end
      else if (r < 25) wr(4'd1, 16'($urandom_range(0, 31)));
      else if (r < 27) wr(4'd0, 16'($urandom_range(0, 511)));
    end
    check_status(); check_head();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule